// File: doc/BRIEF.md
# Converter Serial Readout Port

This block moves a 16-bit conversion result out through a single serial data line. A result word and a one-cycle result-ready strobe load it into a shift register. A host then reads the word while its chip-select and read inputs are both low. Bits leave most significant first. After the last bit the data line rests low until the next result is loaded.

Two clock sources are available. With the internal source, the block makes its own serial clock from the system clock, divided by the parameter `CLK_DIV`, and it frames the transfer with a sync output. With the external source, a host-supplied serial clock shifts the data. That clock passes through a two-stage synchronizer and is gated by chip select. One control chooses which serial clock edge updates the data line, and another sets the polarity of the sync output. In external mode, a result that arrives while a read is only part done discards the partly read word and raises a one-cycle error pulse.

Top module: `cnv_serial_readout`

## Requirements
- R1: After reset, `sdo` and `rd_err` are 0, `sync_out` sits at its inactive level (equal to `inv_sync`), `sclk_out` sits at its idle level (equal to `inv_edge`), and no word is readable until a result has been loaded.
- R2: `sdo` is 0 unless `cs_n` and `rd_n` are both 0.
- R3: A loaded word appears on `sdo` most significant bit first, one bit per update edge. After the 16th bit `sdo` stays 0 until a new result is loaded.
- R4: With `clk_src_ext`=0, a frame starts when `cs_n` and `rd_n` are both 0 and a freshly loaded, unread word is present. During the frame `sclk_out` makes 16 full periods of `CLK_DIV` system clocks each. Outside a frame it holds its idle level.
- R5: With `inv_edge`=0, `sdo` changes on falling serial clock edges and the clock idles low. With `inv_edge`=1, `sdo` changes on rising edges and the clock idles high. This holds in both clock modes.
- R6: With `clk_src_ext`=0, `sync_out` is at its active level for the whole frame. The active level is high when `inv_sync`=0 and low when `inv_sync`=1. With `clk_src_ext`=1, `sync_out` stays inactive.
- R7: With `clk_src_ext`=1, `ext_sclk` passes through two synchronizer flops. Its update edge shifts the register on the third rising system clock edge after it changes, but only while `cs_n` is 0. Edges seen while `cs_n` is 1 shift nothing.
- R8: With `clk_src_ext`=1, a `res_valid` strobe that arrives when 1 to 15 bits have been shifted pulses `rd_err` high for exactly the one cycle after the strobe. The new word replaces the old one, and reading restarts at its most significant bit.
- R9: `rd_err` stays 0 when a result arrives with no bit shifted yet, when it arrives after all 16 bits are out, and when it arrives with `clk_src_ext`=0.
- R10: If a result-ready strobe and an external shift edge act on the same system clock edge, the load wins. The new word is read complete from its most significant bit, and R8 still applies.
- R11: With `clk_src_ext`=0, a result-ready strobe during a frame ends that frame on the next cycle: the sync goes inactive and the clock returns to idle. A new frame for the new word starts while the read stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_word | input | 16 | Conversion result to be shifted out |
| res_valid | input | 1 | One-cycle strobe: `res_word` is new |
| cs_n | input | 1 | Chip select, active low; also gates `ext_sclk` |
| rd_n | input | 1 | Read strobe, active low |
| clk_src_ext | input | 1 | 0: internal serial clock, 1: external serial clock |
| inv_edge | input | 1 | Chooses the serial clock edge that updates `sdo` |
| inv_sync | input | 1 | 0: sync active high, 1: sync active low |
| ext_sclk | input | 1 | External serial clock (asynchronous) |
| sdo | output | 1 | Serial data out |
| sclk_out | output | 1 | Generated serial clock |
| sync_out | output | 1 | Frame sync |
| rd_err | output | 1 | Incomplete-read error pulse |

## Verification
In external mode, the result-ready strobe and a synchronized shift edge can act on the same system clock edge. The bench provokes this by raising `res_valid` exactly two system clocks after it moves `ext_sclk` to its update level, so the load and the shift both land on the third edge. It judges the outcome in three ways. `rd_err` must pulse. The new word's most significant bit must be on `sdo` at once. A full 16-bit read of the new word must then come back intact, which would fail if the shift had consumed a bit.

// File: rtl/cnv_sro_pkg.sv
// Package: shared constants and types for the serial readout port.
// Assumes: result words are 16 bits wide and the external clock uses a two-flop synchronizer.
package cnv_sro_pkg;
    localparam int unsigned SRO_WORD_W      = 16;
    localparam int unsigned SRO_SYNC_STAGES = 2;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } clk_src_e;
endpackage

// File: rtl/cnv_sro_edge.sv
// Module: synchronizes the asynchronous external serial clock and emits a
// one-cycle tick on the selected (update) edge while the gate is open.
// Assumes: the external clock is slower than a few system clock periods.
module cnv_sro_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic gate,
    input  logic rise_sel,
    output logic tick
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              s;

    generate
        if (STAGES == 1) begin : g_one
            // Single-stage capture; during reset it tracks the pin so no false edge follows.
            always_ff @(posedge clk) begin
                chain[0] <= pin;
            end
        end else begin : g_many
            // Multi-stage capture chain; during reset it fills with the pin level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{pin}};
                else        chain <= {chain[STAGES-2:0], pin};
            end
        end
    endgenerate

    assign s = chain[STAGES-1];

    // Previous synchronized level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= pin;
        else        prev <= s;
    end

    assign tick = gate && (rise_sel ? (s && !prev) : (!s && prev));
endmodule

// File: rtl/cnv_sro_clkgen.sv
// Module: internal serial clock generator. Runs a half-period counter only
// during a frame and reports an update tick on each update edge.
// Assumes: CLK_DIV is even and at least 2; stop has priority over start.
module cnv_sro_clkgen #(
    parameter int unsigned CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic last_bit,
    output logic active,
    output logic phase,
    output logic upd_tick
);
    localparam int unsigned HALF = CLK_DIV / 2;
    localparam int unsigned HW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [HW-1:0] hcnt;
    logic          half_done;

    assign half_done = (hcnt == HW'(HALF - 1));
    assign upd_tick  = active && half_done && phase;

    // Frame state, phase and half-period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || stop) begin
            active <= 1'b0;
            phase  <= 1'b0;
            hcnt   <= '0;
        end else if (start) begin
            active <= 1'b1;
            phase  <= 1'b0;
            hcnt   <= '0;
        end else if (active) begin
            if (half_done) begin
                hcnt  <= '0;
                phase <= !phase;
                if (phase && last_bit) active <= 1'b0;
            end else begin
                hcnt <= hcnt + HW'(1);
            end
        end
    end

    // R4
    idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !start) |=> !phase);
endmodule

// File: rtl/cnv_sro_shift.sv
// Module: result shift register with bit counter and overrun error flag.
// Assumes: a load always wins over a shift in the same cycle.
module cnv_sro_shift #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              shift,
    input  logic              ext_mode,
    input  logic              cs_n,
    output logic              msb,
    output logic              fresh,
    output logic              done,
    output logic              last_bit,
    output logic              err
);
    localparam int unsigned CW = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] sr;
    logic [CW-1:0]     cnt;

    assign msb      = sr[WORD_W-1];
    assign fresh    = (cnt == '0);
    assign done     = (cnt == CW'(WORD_W));
    assign last_bit = (cnt == CW'(WORD_W - 1));

    // Load, shift and overrun detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= CW'(WORD_W);
            err <= 1'b0;
        end else begin
            err <= load && ext_mode && !fresh && !done;
            if (load) begin
                sr  <= word;
                cnt <= '0;
            end else if (shift && !done) begin
                sr  <= {sr[WORD_W-2:0], 1'b0};
                cnt <= cnt + CW'(1);
            end
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(WORD_W));
    // R7
    cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && cs_n && !load) |=> $stable(cnt));
    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
    // R8
    err_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> fresh);
endmodule

// File: rtl/cnv_serial_readout.sv
// Module: top of the converter serial readout port. Selects internal or
// external serial clock, gates the data line with chip select and read,
// and produces the frame sync and overrun error.
// Assumes: control inputs are synchronous to clk; ext_sclk may be asynchronous.
module cnv_serial_readout
    import cnv_sro_pkg::*;
#(
    parameter int unsigned WORD_W  = SRO_WORD_W,
    parameter int unsigned CLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] res_word,
    input  logic              res_valid,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              clk_src_ext,
    input  logic              inv_edge,
    input  logic              inv_sync,
    input  logic              ext_sclk,
    output logic              sdo,
    output logic              sclk_out,
    output logic              sync_out,
    output logic              rd_err
);
    clk_src_e src;
    logic     is_ext;
    logic     rd_en;
    logic     ext_tick, gen_tick, shift;
    logic     frame_active, phase, frame_go;
    logic     msb, fresh, done, last_bit;

    assign src    = clk_src_e'(clk_src_ext);
    assign is_ext = (src == SRC_EXTERNAL);
    assign rd_en  = !cs_n && !rd_n;

    cnv_sro_edge #(.STAGES(SRO_SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (ext_sclk),
        .gate     (is_ext && !cs_n),
        .rise_sel (inv_edge),
        .tick     (ext_tick)
    );

    assign frame_go = !is_ext && rd_en && fresh && !frame_active && !res_valid;

    cnv_sro_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (frame_go),
        .stop     (res_valid),
        .last_bit (last_bit),
        .active   (frame_active),
        .phase    (phase),
        .upd_tick (gen_tick)
    );

    assign shift = is_ext ? ext_tick : gen_tick;

    cnv_sro_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (res_valid),
        .word     (res_word),
        .shift    (shift),
        .ext_mode (is_ext),
        .cs_n     (cs_n),
        .msb      (msb),
        .fresh    (fresh),
        .done     (done),
        .last_bit (last_bit),
        .err      (rd_err)
    );

    assign sdo      = rd_en && !done && (is_ext || frame_active) && msb;
    assign sclk_out = is_ext ? inv_edge : (phase ^ inv_edge);
    assign sync_out = (frame_active && !is_ext) ^ inv_sync;

    // R4
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_active && !is_ext) |-> (sclk_out == inv_edge));
    // R6
    sync_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ext |-> (sync_out == inv_sync));
    // R11
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !is_ext) |=> !frame_active);
endmodule

// File: tb/sim_cnv_serial_readout.sv
module sim_cnv_serial_readout;
    localparam int CLK_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n, res_valid, cs_n, rd_n, clk_src_ext, inv_edge, inv_sync, ext_sclk;
    logic [15:0] res_word;
    logic        sdo, sclk_out, sync_out, rd_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic exp_q[$];
    bit   mon_en = 1'b0;
    logic sclk_prev = 1'b0;
    int   last_samp = -1;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    cnv_serial_readout #(.CLK_DIV(CLK_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .res_word(res_word), .res_valid(res_valid),
        .cs_n(cs_n), .rd_n(rd_n), .clk_src_ext(clk_src_ext), .inv_edge(inv_edge),
        .inv_sync(inv_sync), .ext_sclk(ext_sclk), .sdo(sdo), .sclk_out(sclk_out),
        .sync_out(sync_out), .rd_err(rd_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) exp_q.push_back(w[i]);
    endtask

    task automatic load_word(input logic [15:0] w);
        res_word  = w;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic wait_sync(input logic lvl, input int maxc, input string req);
        int n = 0;
        while (sync_out !== lvl && n < maxc) begin
            @(negedge clk);
            n++;
        end
        chk(req, sync_out, lvl);
    endtask

    // Monitor: receiver for internal-clock frames, pops expected bits on sample edges.
    always @(negedge clk) begin
        if (mon_en && sclk_out !== sclk_prev && sclk_out === ~inv_edge) begin
            if (exp_q.size() == 0) begin
                chk("R3 extra bit in frame", 1, 0);
            end else begin
                logic e;
                e = exp_q.pop_front();
                chk("R3/R5 master bit", sdo, e);
            end
            if (last_samp >= 0) chk("R4 sclk period", cyc - last_samp, CLK_DIV);
            last_samp = cyc;
        end
        if (!mon_en) last_samp = -1;
        sclk_prev = sclk_out;
    end

    task automatic master_read(input logic [15:0] w);
        push_word(w);
        mon_en = 1'b1;
        cs_n = 1'b0;
        rd_n = 1'b0;
        wait_sync(~inv_sync, 10, "R6 sync active");
        wait_sync(inv_sync, 200, "R6 sync released");
        chk("R3 sdo low after frame", sdo, 0);
        chk("R3 all 16 bits seen", exp_q.size(), 0);
        chk("R4 sclk idle after frame", sclk_out, inv_edge);
        mon_en = 1'b0;
        cs_n = 1'b1;
        rd_n = 1'b1;
        @(negedge clk);
    endtask

    // Slave reader: sample edge, compare, update edge.
    task automatic slave_bits(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            logic e;
            ext_sclk = ~inv_edge;
            repeat (6) @(negedge clk);
            e = exp_q.pop_front();
            chk(req, sdo, e);
            ext_sclk = inv_edge;
            repeat (6) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; res_valid = 1'b0; res_word = '0; cs_n = 1'b1; rd_n = 1'b1;
        clk_src_ext = 1'b0; inv_edge = 1'b0; inv_sync = 1'b0; ext_sclk = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sdo reset", sdo, 0);
        chk("R1 rd_err reset", rd_err, 0);
        chk("R1 sync reset", sync_out, 0);
        chk("R1 sclk reset", sclk_out, 0);
        cs_n = 1'b0; rd_n = 1'b0;
        repeat (20) @(negedge clk);
        chk("R1 no frame without result", sync_out, 0);
        chk("R1 no clock without result", sclk_out, 0);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);

        // Internal clock, default edge and polarity.
        load_word(16'hA5C3);
        master_read(16'hA5C3);

        // Internal clock, inverted edge and sync.
        inv_edge = 1'b1; inv_sync = 1'b1;
        @(negedge clk);
        chk("R5 idle clock high", sclk_out, 1);
        chk("R6 inactive sync high", sync_out, 1);
        load_word(16'h8001);
        master_read(16'h8001);

        // External clock: output gating (R2).
        inv_edge = 1'b0; inv_sync = 1'b0; clk_src_ext = 1'b1; ext_sclk = 1'b0;
        @(negedge clk);
        load_word(16'h9C31);
        cs_n = 1'b1; rd_n = 1'b0; @(negedge clk);
        chk("R2 sdo off with cs_n high", sdo, 0);
        cs_n = 1'b0; rd_n = 1'b1; @(negedge clk);
        chk("R2 sdo off with rd_n high", sdo, 0);
        cs_n = 1'b0; rd_n = 1'b0; @(negedge clk);
        chk("R2 sdo on when both low", sdo, 1);
        chk("R6 sync inactive in external mode", sync_out, 0);

        // Clock edges with cs_n high are ignored (R7).
        cs_n = 1'b1; rd_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            ext_sclk = 1'b1; repeat (6) @(negedge clk);
            ext_sclk = 1'b0; repeat (6) @(negedge clk);
        end
        cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        push_word(16'h9C31);
        slave_bits(16, "R7 slave bit after gated edges");
        chk("R3 sdo low after 16 slave bits", sdo, 0);

        // No error after complete read or before any bit (R9).
        load_word(16'h3E6B);
        chk("R9 no error after complete read", rd_err, 0);
        load_word(16'h3E6B);
        chk("R9 no error before first bit", rd_err, 0);

        // Overrun (R8).
        exp_q.delete();
        push_word(16'h3E6B);
        slave_bits(5, "R8 partial read bit");
        load_word(16'hC4D7);
        chk("R8 error pulse", rd_err, 1);
        @(negedge clk);
        chk("R8 error one cycle", rd_err, 0);
        exp_q.delete();
        push_word(16'hC4D7);
        slave_bits(16, "R8 new word after overrun");

        // Coincident load and shift, inverted edge (R10, R5).
        cs_n = 1'b1; rd_n = 1'b1; inv_edge = 1'b1; ext_sclk = 1'b1;
        repeat (6) @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        load_word(16'h5A0F);
        exp_q.delete();
        push_word(16'h5A0F);
        slave_bits(3, "R5 slave rising-update bit");
        ext_sclk = 1'b0; repeat (6) @(negedge clk);
        ext_sclk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        res_word = 16'hB2E9; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        chk("R10 error on coincident load", rd_err, 1);
        chk("R10 new MSB on sdo", sdo, 1);
        exp_q.delete();
        push_word(16'hB2E9);
        slave_bits(16, "R10 word intact after coincidence");
        chk("R3 sdo low after word", sdo, 0);

        // Internal-clock abort (R11, R9).
        cs_n = 1'b1; rd_n = 1'b1; inv_edge = 1'b0; ext_sclk = 1'b0; clk_src_ext = 1'b0;
        @(negedge clk);
        load_word(16'h6D14);
        cs_n = 1'b0; rd_n = 1'b0;
        wait_sync(1'b1, 10, "R11 first frame starts");
        repeat (10) @(negedge clk);
        load_word(16'hF00D);
        chk("R9 no error in internal mode", rd_err, 0);
        chk("R11 frame aborted", sync_out, 0);
        chk("R11 clock idle after abort", sclk_out, 0);
        exp_q.delete();
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        master_read(16'hF00D);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule